// File: doc/BRIEF.md
# Light sensor measurement sequencer

This block takes one ambient light reading from a two-wire light sensor each time a start pulse arrives. It does not toggle the bus lines itself. It drives a byte-level I2C master through a small command port. Each command is a request pulse that carries an operation (START, WRITE, READ or STOP), a write byte and, for reads, the acknowledge bit to send. The master returns a busy level and a done pulse, which carries the read byte and a flag that reports a missing acknowledge.

A reading has two phases. In the first phase the block addresses the sensor for writing, sends the measurement command 8'h10 and closes the transfer. It then waits a fixed conversion time, set by the clock frequency and a millisecond count. In the second phase it addresses the sensor for reading, collects two bytes with the high byte first, and closes the transfer again. The 16-bit count is then held in a result register and marked by a one-cycle valid strobe, so a serial transmitter can forward it as two bytes. If any address or command byte is not acknowledged, the block closes the bus and reports an error.

Top module: `light_meas_seq`

## Requirements
- R1: The 7-bit sensor address is 7'b0100011 when addr_sel_i is low and 7'b1011100 when it is high. The address bytes are therefore 8'h46 (write) and 8'h47 (read) when the strap is low, and 8'hB8 and 8'hB9 when it is high.
- R2: Operation codes on i2c_op_o are START=0, WRITE=1, READ=2 and STOP=3. A successful reading issues exactly these commands, in this order: START, WRITE write-address, WRITE 8'h10, STOP, START, WRITE read-address, READ, READ, STOP.
- R3: The read-phase START is requested exactly WAIT_CYC = CLK_HZ/1000*WAIT_MS cycles after the cycle in which the first STOP completes.
- R4: The first READ is issued with i2c_last_o=0 (ACK) and the second with i2c_last_o=1 (NACK). The result is {first byte, second byte}.
- R5: One cycle after the final STOP completes, done_o and valid_o pulse high for one cycle, err_o stays low, and result_o shows the new value.
- R6: If a WRITE completes with i2c_nack_i high, the next command is a STOP. When that STOP completes, done_o and err_o pulse together, valid_o stays low, and result_o keeps its previous value.
- R7: busy_o rises in the cycle after an accepted start pulse and stays high until the cycle in which done_o pulses. A start pulse that arrives while busy_o is high is ignored.
- R8: After reset, busy_o, done_o, err_o, valid_o and i2c_req_o are low and result_o is zero.
- R9: A command request is raised only while i2c_busy_i is low, and each command is raised once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle pulse that starts a reading |
| addr_sel_i | input | 1 | Address strap |
| i2c_busy_i | input | 1 | Master is executing a command |
| i2c_done_i | input | 1 | Master finished the current command |
| i2c_nack_i | input | 1 | With done: the written byte was not acknowledged |
| i2c_rdata_i | input | 8 | With done: the byte that was read |
| i2c_req_o | output | 1 | Command request pulse |
| i2c_op_o | output | 2 | Command operation code |
| i2c_wdata_o | output | 8 | Byte to write |
| i2c_last_o | output | 1 | For READ: send NACK after this byte |
| busy_o | output | 1 | A reading is in progress |
| done_o | output | 1 | Reading finished (pulse) |
| err_o | output | 1 | Reading aborted on a missing acknowledge (pulse with done) |
| result_o | output | 16 | Last good 16-bit count |
| valid_o | output | 1 | result_o was just updated (pulse) |

## Verification
A behavioural master model serves the command port. It logs every command, returns chosen bytes and can withhold the acknowledge on any chosen write. Readings are taken with both strap levels and several byte pairs. Pairs with all-ones and all-zero halves, and pairs with only the top or only the bottom bit set, show whether the bytes are swapped or the halves misplaced. Separate runs refuse the acknowledge on the write address, on the command byte and on the read address; these show whether the abort comes at the right point of the sequence and whether the old result is kept. A run with extra start pulses during the conversion wait shows that they are ignored.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START_W, ST_ADDR_W, ST_CMD, ST_STOP_W, ST_WAIT,
    ST_START_R, ST_ADDR_R, ST_RD_HI, ST_RD_LO, ST_STOP_R, ST_ABORT
  } seq_st_e;

  localparam int          BYTE_W    = 8;
  localparam logic [6:0]  ADDR_LO   = 7'b0100011;
  localparam logic [6:0]  ADDR_HI   = 7'b1011100;
  localparam logic [7:0]  MEAS_CMD  = 8'h10;
endpackage

// File: rtl/lms_wait_timer.sv
module lms_wait_timer #(
  parameter int WAIT_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = en_i && (cnt_q == LAST);

  // R3
  cnt_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/lms_result_reg.sv
module lms_result_reg #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] byte_i,
  input  logic          cap_hi_i,
  input  logic          cap_lo_i,
  input  logic          commit_i,
  output logic [2*BW-1:0] result_o,
  output logic          valid_o
);
  logic [BW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      lo_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q <= byte_i;
      if (cap_lo_i) lo_q <= byte_i;
      if (commit_i) result_o <= {hi_q, lo_q};
      valid_o <= commit_i;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/lms_seq_fsm.sv
module lms_seq_fsm
  import lms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       addr_sel_i,
  input  logic       expired_i,
  output logic       wait_en_o,
  input  logic       i2c_busy_i,
  input  logic       i2c_done_i,
  input  logic       i2c_nack_i,
  output logic       req_o,
  output logic [1:0] op_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic       last_o,
  output logic       cap_hi_o,
  output logic       cap_lo_o,
  output logic       commit_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  seq_st_e    state_q, state_d;
  logic       issued_q;
  logic       step_done, is_cmd, is_wr;
  logic [6:0] addr;
  i2c_op_e    op;

  assign addr      = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign is_cmd    = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign is_wr     = (state_q == ST_ADDR_W) || (state_q == ST_CMD) || (state_q == ST_ADDR_R);
  assign step_done = issued_q && i2c_done_i;
  assign req_o     = is_cmd && !issued_q && !i2c_busy_i;
  assign wait_en_o = (state_q == ST_WAIT);
  assign busy_o    = (state_q != ST_IDLE);
  assign cap_hi_o  = (state_q == ST_RD_HI) && step_done;
  assign cap_lo_o  = (state_q == ST_RD_LO) && step_done;
  assign commit_o  = (state_q == ST_STOP_R) && step_done;
  assign last_o    = (state_q == ST_RD_LO);
  assign op_o      = op;

  always_comb begin
    unique case (state_q)
      ST_START_W, ST_START_R:          op = OP_START;
      ST_ADDR_W, ST_CMD, ST_ADDR_R:    op = OP_WRITE;
      ST_RD_HI, ST_RD_LO:              op = OP_READ;
      default:                         op = OP_STOP;
    endcase
    unique case (state_q)
      ST_ADDR_W: wdata_o = {addr, 1'b0};
      ST_CMD:    wdata_o = MEAS_CMD;
      ST_ADDR_R: wdata_o = {addr, 1'b1};
      default:   wdata_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (start_i) state_d = ST_START_W;
    end else if (state_q == ST_WAIT) begin
      if (expired_i) state_d = ST_START_R;
    end else if (step_done) begin
      if (is_wr && i2c_nack_i) state_d = ST_ABORT;
      else begin
        unique case (state_q)
          ST_START_W: state_d = ST_ADDR_W;
          ST_ADDR_W:  state_d = ST_CMD;
          ST_CMD:     state_d = ST_STOP_W;
          ST_STOP_W:  state_d = ST_WAIT;
          ST_START_R: state_d = ST_ADDR_R;
          ST_ADDR_R:  state_d = ST_RD_HI;
          ST_RD_HI:   state_d = ST_RD_LO;
          ST_RD_LO:   state_d = ST_STOP_R;
          default:    state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= step_done ? 1'b0 : (req_o ? 1'b1 : issued_q);
      done_o   <= commit_o || ((state_q == ST_ABORT) && step_done);
      err_o    <= (state_q == ST_ABORT) && step_done;
    end
  end

  // R6
  nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && step_done && i2c_nack_i) |=> (op_o == OP_STOP));
  // R9
  req_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/light_meas_seq.sv
module light_meas_seq
  import lms_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int WAIT_MS = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        addr_sel_i,
  input  logic        i2c_busy_i,
  input  logic        i2c_done_i,
  input  logic        i2c_nack_i,
  input  logic [7:0]  i2c_rdata_i,
  output logic        i2c_req_o,
  output logic [1:0]  i2c_op_o,
  output logic [7:0]  i2c_wdata_o,
  output logic        i2c_last_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] result_o,
  output logic        valid_o
);
  localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;

  logic wait_en, expired, cap_hi, cap_lo, commit;

  lms_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk_i, .rst_ni, .en_i(wait_en), .expired_o(expired)
  );

  lms_seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .addr_sel_i,
    .expired_i(expired), .wait_en_o(wait_en),
    .i2c_busy_i, .i2c_done_i, .i2c_nack_i,
    .req_o(i2c_req_o), .op_o(i2c_op_o), .wdata_o(i2c_wdata_o), .last_o(i2c_last_o),
    .cap_hi_o(cap_hi), .cap_lo_o(cap_lo), .commit_o(commit),
    .busy_o, .done_o, .err_o
  );

  lms_result_reg #(.BW(BYTE_W)) u_res (
    .clk_i, .rst_ni, .byte_i(i2c_rdata_i),
    .cap_hi_i(cap_hi), .cap_lo_i(cap_lo), .commit_i(commit),
    .result_o, .valid_o
  );

  // R7
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R5
  valid_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (done_o && !err_o));
  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(result_o));
endmodule

// File: tb/light_meas_seq_test.sv
module light_meas_seq_test;
  localparam int CLK_HZ   = 50_000;
  localparam int WAIT_MS  = 2;
  localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
  localparam int LAT      = 3;
  localparam int NV       = 6;
  // {sel, nack stage(2), hi, lo}; stage 0 none, 1 write addr, 2 command, 3 read addr
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h12, 8'h34},
    {1'b1, 2'd0, 8'hFF, 8'h00},
    {1'b0, 2'd2, 8'hAB, 8'hCD},
    {1'b1, 2'd1, 8'h00, 8'h01},
    {1'b0, 2'd3, 8'h5A, 8'hA5},
    {1'b1, 2'd0, 8'h80, 8'h7F}
  };

  logic clk = 0, rst_n = 0, start = 0, addr_sel = 0;
  logic i2c_busy = 0, i2c_done = 0, i2c_nack = 0;
  logic [7:0] i2c_rdata = 0;
  logic req, last, busy, done, err, valid;
  logic [1:0] op;
  logic [7:0] wdata;
  logic [15:0] result;

  int errors = 0, checks = 0, cyc = 0;
  int n_ops, n_wr, n_rd, nack_at, busy_viol = 0;
  logic [7:0] rd_hi, rd_lo;
  logic [1:0] log_op [16];
  logic [7:0] log_data [16];
  logic       log_last [16];
  int         log_cyc [16];
  int         log_end [16];

  light_meas_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_sel_i(addr_sel),
    .i2c_busy_i(i2c_busy), .i2c_done_i(i2c_done), .i2c_nack_i(i2c_nack),
    .i2c_rdata_i(i2c_rdata), .i2c_req_o(req), .i2c_op_o(op),
    .i2c_wdata_o(wdata), .i2c_last_o(last), .busy_o(busy), .done_o(done),
    .err_o(err), .result_o(result), .valid_o(valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // master model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req) begin
        int k;
        logic [1:0] o;
        if (i2c_busy) busy_viol++;
        k = n_ops;
        o = op;
        if (k < 16) begin
          log_op[k] = op; log_data[k] = wdata; log_last[k] = last; log_cyc[k] = cyc;
        end
        n_ops++;
        @(posedge clk); #1 i2c_busy = 1;
        repeat (LAT) @(posedge clk);
        #1 i2c_busy = 0; i2c_done = 1; i2c_nack = 0; i2c_rdata = 0;
        if (o == 2'd1) begin n_wr++; i2c_nack = (n_wr == nack_at); end
        if (o == 2'd2) begin i2c_rdata = (n_rd == 0) ? rd_hi : rd_lo; n_rd++; end
        @(posedge clk); #1 i2c_done = 0; i2c_nack = 0;
        if (k < 16) log_end[k] = cyc;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  task automatic run_meas(input logic sel, input logic [1:0] nst, input logic [7:0] hi,
                          input logic [7:0] lo, input int extra_starts,
                          output logic o_err, output logic o_valid, output logic [15:0] o_res);
    int t;
    n_ops = 0; n_wr = 0; n_rd = 0; nack_at = nst; rd_hi = hi; rd_lo = lo;
    addr_sel = sel;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(busy === 1'b1, "R7", "busy after start", busy, 1);
    for (int i = 0; i < extra_starts; i++) begin
      repeat (17) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    o_err = err; o_valid = valid; o_res = result;
    chk(busy === 1'b0, "R7", "busy low at done", busy, 0);
  endtask

  task automatic check_log(input logic sel, input logic [1:0] nst);
    logic [1:0] full_op [9];
    int k, exp_n, bad;
    logic [7:0] aw, ar;
    full_op = '{2'd0, 2'd1, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd3};
    aw = sel ? 8'hB8 : 8'h46;
    ar = sel ? 8'hB9 : 8'h47;
    k = (nst == 2'd1) ? 2 : (nst == 2'd2) ? 3 : (nst == 2'd3) ? 6 : 9;
    exp_n = (nst == 2'd0) ? 9 : k + 1;
    chk(n_ops == exp_n, (nst == 0) ? "R2" : "R6", "command count", n_ops, exp_n);
    bad = 0;
    for (int i = 0; i < k && i < 16; i++) if (log_op[i] !== full_op[i]) bad++;
    if (nst != 0 && log_op[k] !== 2'd3) bad++;
    chk(bad == 0, (nst == 0) ? "R2" : "R6", "command order", bad, 0);
    chk(log_data[1] === aw, "R1", "write address", log_data[1], aw);
    if (k > 2) chk(log_data[2] === 8'h10, "R2", "command byte", log_data[2], 8'h10);
    if (k > 5) begin
      chk(log_data[5] === ar, "R1", "read address", log_data[5], ar);
      chk(log_cyc[4] - log_end[3] == WAIT_CYC, "R3", "wait length",
          log_cyc[4] - log_end[3], WAIT_CYC);
    end
    if (nst == 0) begin
      chk(log_last[6] === 1'b0, "R4", "first read ack", log_last[6], 0);
      chk(log_last[7] === 1'b1, "R4", "second read nack", log_last[7], 1);
    end
  endtask

  initial begin
    logic e, v;
    logic [15:0] r, prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0, "R8", "reset flags", {busy, done, err}, 0);
    chk(valid === 0 && req === 0, "R8", "reset valid/req", {valid, req}, 0);
    chk(result === 16'h0, "R8", "reset result", result, 0);
    prev = 16'h0;

    for (int i = 0; i < NV; i++) begin
      logic [18:0] vv;
      vv = VEC[i];
      run_meas(vv[18], vv[17:16], vv[15:8], vv[7:0], 0, e, v, r);
      check_log(vv[18], vv[17:16]);
      if (vv[17:16] == 2'd0) begin
        chk(e === 0 && v === 1, "R5", "valid/err on success", {e, v}, 2'b01);
        chk(r === vv[15:0], "R4", "result bytes", r, vv[15:0]);
        prev = vv[15:0];
      end else begin
        chk(e === 1 && v === 0, "R6", "err/valid on abort", {e, v}, 2'b10);
        chk(r === prev, "R6", "result held", r, prev);
      end
      @(negedge clk);
      chk(done === 0 && valid === 0, "R5", "single-cycle strobes", {done, valid}, 0);
    end

    // extra starts during measurement
    run_meas(1'b0, 2'd0, 8'h3C, 8'hC3, 4, e, v, r);
    repeat (30) @(negedge clk);
    chk(n_ops == 9, "R7", "starts while busy ignored", n_ops, 9);
    chk(busy === 0, "R7", "idle after run", busy, 0);
    chk(r === 16'h3CC3, "R4", "result with extra starts", r, 16'h3CC3);
    chk(busy_viol == 0, "R9", "request while master busy", busy_viol, 0);

    finish_run();
  end
endmodule